// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block runs hardware loops for an in-order instruction fetch stage. A repeat command gives it an iteration count and the first and last addresses of a loop body. From then on it watches the fetch program counter. Each time fetch reaches the last body address, the block overrides the next PC back to the first body address and decrements a dedicated down-counter. No branch instruction is fetched or decoded for this, and no compare-and-branch code is needed.

The count operand gives the number of extra passes, so the body runs count+1 times. A count of zero runs the body once and never loops back. A body whose first and last addresses are equal repeats a single instruction. Setting up a loop asks the fetch stage for exactly one flush. The loop-back and exit boundaries cost no flush, so the pipeline stays full of body instructions for the whole loop. Only one loop level is held. A repeat command that arrives while a loop is running is dropped and reported on an error pulse.

Top module: `zol_ctrl`

## Requirements
- R1: A repeat command (`rpt_valid`=1) while no loop is active is accepted. Its count, first address and last address are captured, and `loop_active` reads 1 from the next clock cycle on.
- R2: `flush_req` is 1 for exactly the one cycle after an accepted repeat command, and it is 0 in every other cycle.
- R3: While `loop_active`=1, `fetch_adv`=1, `fetch_pc` equals the captured last address and the remaining count is non-zero, `redirect_valid`=1 and `redirect_pc` equals the captured first address in that same cycle, with no register in between.
- R4: Each loop-back decrements the remaining count by one. A command with count N therefore passes through the last body address N+1 times before the loop ends.
- R5: While `loop_active`=1, `fetch_adv`=1, `fetch_pc` equals the last address and the remaining count is zero, `redirect_valid`=1 and `redirect_pc` is the last address plus one (modulo 2^AW). `loop_active` reads 0 from the next cycle on.
- R6: A count of zero runs the body once and never redirects back to the first address.
- R7: When the first and last addresses are equal, that single instruction repeats count+1 times.
- R8: A repeat command received while `loop_active`=1 is ignored. The running loop keeps its bounds and count, and `rpt_error` is 1 for the following cycle only.
- R9: `redirect_valid` is 0 whenever `loop_active`=0, `fetch_adv`=0, or `fetch_pc` differs from the last address.
- R10: During and right after reset, `loop_active`, `flush_req`, `rpt_error` and `redirect_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_valid | input | 1 | Repeat command strobe |
| rpt_count | input | CW (8) | Extra passes; the body runs this value plus one times |
| rpt_first | input | AW (16) | First address of the loop body |
| rpt_last | input | AW (16) | Last address of the loop body |
| fetch_adv | input | 1 | Fetch stage consumes `fetch_pc` this cycle |
| fetch_pc | input | AW (16) | Current fetch program counter |
| redirect_valid | output | 1 | Override the next fetch PC with `redirect_pc` |
| redirect_pc | output | AW (16) | Next fetch PC when an override is requested |
| loop_active | output | 1 | A loop is currently being sequenced |
| flush_req | output | 1 | One-cycle flush request at loop setup |
| rpt_error | output | 1 | Pulse: a repeat command was dropped |

## Verification
A wrong remaining count has no visible effect until fetch reaches the last body address. At that point it shows up in the same cycle as a redirect to the wrong place, either back to the first address when the loop should exit or out of the loop when it should go back. A stuck or wrong active flag shows up one cycle later on `loop_active`, or as a redirect while no loop is active. The bench steps a fetch PC through each loop under a behavioural model and compares every output on every cycle, so a fault appears at the first boundary that reaches it. It also counts the passes through the last address, which exposes an off-by-one in the count.

// File: rtl/zol_pkg.sv
package zol_pkg;
  // Why the fetch PC is being overridden this cycle.
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_BACK = 2'd1,
    RD_EXIT = 2'd2
  } redir_e;
endpackage

// File: rtl/zol_cmd.sv
module zol_cmd #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_first,
  input  logic [AW-1:0] cmd_last,
  input  logic          exit_evt,
  output logic          accept,
  output logic          active,
  output logic          flush,
  output logic          err,
  output logic [AW-1:0] blk_first,
  output logic [AW-1:0] blk_last
);
  logic reject;

  assign accept = cmd_valid && !active;
  assign reject = cmd_valid && active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      flush     <= 1'b0;
      err       <= 1'b0;
      blk_first <= '0;
      blk_last  <= '0;
    end else begin
      flush <= accept;
      err   <= reject;
      if (accept) begin
        active    <= 1'b1;
        blk_first <= cmd_first;
        blk_last  <= cmd_last;
      end else if (exit_evt) begin
        active <= 1'b0;
      end
    end
  end

  assert_accept_sets_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> active);
  assert_flush_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);
  assert_flush_needs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(accept));
  assert_reject_keeps_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err && $stable(blk_first) && $stable(blk_last) && active));
endmodule

// File: rtl/zol_counter.sv
module zol_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          zero
);
  function automatic logic [CW-1:0] count_after(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= count_after(cnt);
  end

  assign zero = (cnt == '0);

  assert_decrement_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (cnt == CW'($past(cnt) - CW'(1))));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !zero);
endmodule

// File: rtl/zol_redirect.sv
module zol_redirect
  import zol_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          fetch_adv,
  input  logic [AW-1:0] fetch_pc,
  input  logic [AW-1:0] blk_first,
  input  logic [AW-1:0] blk_last,
  input  logic          cnt_zero,
  output redir_e        reason,
  output logic          back_evt,
  output logic          exit_evt,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc
);
  logic at_end;

  function automatic logic [AW-1:0] fall_through(input logic [AW-1:0] last);
    return last + AW'(1);
  endfunction

  assign at_end = active && fetch_adv && (fetch_pc == blk_last);

  always_comb begin
    reason = RD_NONE;
    if (at_end) reason = cnt_zero ? RD_EXIT : RD_BACK;
  end

  assign back_evt       = (reason == RD_BACK);
  assign exit_evt       = (reason == RD_EXIT);
  assign redirect_valid = (reason != RD_NONE);
  assign redirect_pc    = back_evt ? blk_first :
                          exit_evt ? fall_through(blk_last) : '0;

  assert_idle_no_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active || !fetch_adv) |-> !redirect_valid);
  assert_loop_back_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fetch_adv && fetch_pc == blk_last && !cnt_zero) |-> (redirect_valid && redirect_pc == blk_first));
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
  import zol_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rpt_valid,
  input  logic [CW-1:0] rpt_count,
  input  logic [AW-1:0] rpt_first,
  input  logic [AW-1:0] rpt_last,
  input  logic          fetch_adv,
  input  logic [AW-1:0] fetch_pc,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic          loop_active,
  output logic          flush_req,
  output logic          rpt_error
);
  logic          accept, back_evt, exit_evt, cnt_zero;
  logic [AW-1:0] blk_first, blk_last;
  logic [CW-1:0] cnt;
  redir_e        reason;

  zol_cmd #(.AW(AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_valid(rpt_valid), .cmd_first(rpt_first),
    .cmd_last(rpt_last), .exit_evt(exit_evt), .accept(accept), .active(loop_active),
    .flush(flush_req), .err(rpt_error), .blk_first(blk_first), .blk_last(blk_last)
  );

  zol_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(rpt_count),
    .dec(back_evt), .cnt(cnt), .zero(cnt_zero)
  );

  zol_redirect #(.AW(AW)) u_redir (
    .clk(clk), .rst_n(rst_n), .active(loop_active), .fetch_adv(fetch_adv),
    .fetch_pc(fetch_pc), .blk_first(blk_first), .blk_last(blk_last),
    .cnt_zero(cnt_zero), .reason(reason), .back_evt(back_evt), .exit_evt(exit_evt),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  assert_exit_clears_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> !loop_active);
  assert_exit_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |-> (redirect_pc == AW'(blk_last + AW'(1))));
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |=> (!loop_active && !flush_req && !rpt_error));
  assert_redirect_reason_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $onehot0({back_evt, exit_evt}) && (back_evt || exit_evt));
endmodule

// File: tb/zol_ctrl_tb.sv
`timescale 1ns/1ps
module zol_ctrl_tb;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rpt_valid = 1'b0;
  logic [CW-1:0] rpt_count = '0;
  logic [AW-1:0] rpt_first = '0;
  logic [AW-1:0] rpt_last = '0;
  logic          fetch_adv = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          redirect_valid;
  logic [AW-1:0] redirect_pc;
  logic          loop_active, flush_req, rpt_error;

  int checks = 0;
  int fails = 0;
  int m_active = 0, m_cnt = 0, m_first = 0, m_last = 0, m_flush = 0, m_err = 0;
  int pc = 0;
  int ends = 0;
  int backs = 0;

  always #4 clk = ~clk;

  zol_ctrl #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_count(rpt_count),
    .rpt_first(rpt_first), .rpt_last(rpt_last), .fetch_adv(fetch_adv),
    .fetch_pc(fetch_pc), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .loop_active(loop_active), .flush_req(flush_req), .rpt_error(rpt_error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit rv, input int c, input int f, input int l, input bit adv);
    bit hit;
    int exp_pc;
    @(negedge clk);
    rpt_valid = rv; rpt_count = CW'(c); rpt_first = AW'(f); rpt_last = AW'(l);
    fetch_adv = adv; fetch_pc = AW'(pc);
    #1;
    hit = (m_active != 0) && adv && (pc == m_last);
    exp_pc = hit ? ((m_cnt > 0) ? m_first : ((m_last + 1) & MASK)) : 0;
    chk(loop_active == (m_active != 0), "R1", loop_active, m_active);
    chk(flush_req == (m_flush != 0), "R2", flush_req, m_flush);
    chk(rpt_error == (m_err != 0), "R8", rpt_error, m_err);
    if (hit && m_cnt > 0) begin
      chk(redirect_valid == 1'b1, "R3", redirect_valid, 1);
      chk(int'(redirect_pc) == exp_pc, "R3", redirect_pc, exp_pc);
    end else if (hit) begin
      chk(redirect_valid == 1'b1, "R5", redirect_valid, 1);
      chk(int'(redirect_pc) == exp_pc, "R5", redirect_pc, exp_pc);
    end else begin
      chk(redirect_valid == 1'b0, "R9", redirect_valid, 0);
    end
    if (hit) ends++;
    if (hit && m_cnt > 0) backs++;
    // next model state
    m_flush = (rv && m_active == 0) ? 1 : 0;
    m_err   = (rv && m_active != 0) ? 1 : 0;
    if (rv && m_active == 0) begin
      m_active = 1; m_cnt = c; m_first = f; m_last = l;
      pc = f;
    end else begin
      if (hit) begin
        if (m_cnt > 0) m_cnt--;
        else m_active = 0;
      end
      if (adv) pc = hit ? exp_pc : ((pc + 1) & MASK);
    end
  endtask

  task automatic run_loop(input int c, input int f, input int l, input int err_at,
                          input int stall_every, output int passes, output int loops_back);
    int guard;
    ends = 0; backs = 0;
    step(1'b1, c, f, l, 1'b1);
    guard = 0;
    while (m_active != 0 && guard < 5000) begin
      guard++;
      if (guard == err_at) step(1'b1, 7, 16'h0300, 16'h0305, 1'b1);
      else step(1'b0, 0, 0, 0, (stall_every == 0) || (guard % stall_every != 0));
    end
    step(1'b0, 0, 0, 0, 1'b1);
    step(1'b0, 0, 0, 0, 1'b1);
    passes = ends;
    loops_back = backs;
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int p, b;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: quiet during reset
    chk(loop_active == 0, "R10", loop_active, 0);
    chk(flush_req == 0, "R10", flush_req, 0);
    chk(rpt_error == 0, "R10", rpt_error, 0);
    chk(redirect_valid == 0, "R10", redirect_valid, 0);
    rst_n = 1'b1;
    pc = 16'h0008;
    step(1'b0, 0, 0, 0, 1'b1);
    step(1'b0, 0, 0, 0, 1'b1);

    // R4: block loop, count 2 -> 3 passes
    run_loop(2, 16'h0010, 16'h0013, 0, 0, p, b);
    chk(p == 3, "R4", p, 3);
    chk(b == 2, "R4", b, 2);

    // R6: count zero -> one pass, no loop-back
    run_loop(0, 16'h0040, 16'h0042, 0, 0, p, b);
    chk(p == 1, "R6", p, 1);
    chk(b == 0, "R6", b, 0);

    // R7: single instruction repeated count+1 times
    run_loop(3, 16'h0020, 16'h0020, 0, 0, p, b);
    chk(p == 4, "R7", p, 4);

    // R8: repeat command during a loop is dropped, loop unchanged
    run_loop(4, 16'h0050, 16'h0052, 4, 0, p, b);
    chk(p == 5, "R8", p, 5);

    // R9: fetch stalls, redirect only on advancing cycles
    run_loop(5, 16'h0060, 16'h0061, 0, 3, p, b);
    chk(p == 6, "R9", p, 6);

    // R5: exit wraps past the top of the address space
    run_loop(1, 16'hFFFE, 16'hFFFF, 0, 0, p, b);
    chk(p == 2, "R5", p, 2);
    chk(pc == 16'h0002, "R5", pc, 2);

    // R1: a larger count, then a fresh loop accepted right after exit
    run_loop(40, 16'h0100, 16'h0107, 0, 0, p, b);
    chk(p == 41, "R1", p, 41);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule